// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is the register and control logic of a sixteen-pin general-purpose I/O port. Software reaches it through a simple word interface. One shared address selects the register for a write and the register shown on the read data bus, and a read is combinational. Each pin has its own four-bit configuration field. The field chooses the pin's behaviour: input (floating, pulled up or pulled down), analog, or output. An output can be driven from the port's own output data register or from a peripheral signal, and it can use push-pull or open-drain drive.

For every pin the block produces a drive value, an output enable, pull-up and pull-down enables and an alternate-function select. It samples the pin levels on every clock into an input data register. Two extra write-only registers change output bits without a read-modify-write sequence. One sets and clears bits in a single write, and the other only clears them. The pad cells themselves sit outside this block.

Top module: `gpio_port`

Register addresses: 0 = config low (pins 0-7), 1 = config high (pins 8-15), 2 = input data, 3 = output data, 4 = set/clear, 5 = clear-only. Any other address reads as zero and ignores writes.

## Requirements
- R1: After synchronous reset, both config registers read 0x44444444, the output data register reads 0, and every pad_oe, pull_up_en, pull_dn_en and alt_sel bit is 0.
- R2: Pin p uses bits [4*(p%8)+3 : 4*(p%8)] of config low (p<8) or config high (p>=8). Within that nibble, bits [3:2] are the kind and bits [1:0] are the direction. Direction 00 means input. Any non-zero direction means output.
- R3: For an output with kind bit1=0 and kind bit0=0 (push-pull, general purpose), pad_oe=1 and pad_out equals the pin's output data bit.
- R4: When kind bit0=1 in output direction (open-drain), pad_out is 0 and pad_oe is 1 only when the source bit is 0.
- R5: When kind bit1=1 in output direction (alternate function), alt_sel=1 and the source bit is alt_out for that pin, not the output data bit.
- R6: In input direction, kind 10 enables only the pull-up and kind 11 enables only the pull-down. Kinds 00 and 01, and every output configuration, enable no pull.
- R7: The input data register captures pad_in on every clock edge. A level change appears on the input data read one edge later.
- R8: In input direction, kind 00 is analog. That pin's input data bit reads 0, and the pin has pad_oe=0 and no pulls.
- R9: A write to set/clear sets the output bits flagged in data[15:0] and clears those flagged in data[31:16]. If both are flagged for the same pin, the bit ends up set, and unflagged bits keep their value.
- R10: A write to clear-only clears the output bits flagged in data[15:0]. It ignores data[31:16] and leaves other bits unchanged.
- R11: Writes to the input data register have no effect, and the set/clear and clear-only addresses always read 0.
- R12: A write to the output data register loads data[15:0], and a read returns that value in bits [15:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| pad_in | input | 16 | Pin input levels |
| alt_out | input | 16 | Peripheral output signals per pin |
| pad_out | output | 16 | Value each pin drives |
| pad_oe | output | 16 | Output enable per pin |
| pull_up_en | output | 16 | Weak pull-up enable per pin |
| pull_dn_en | output | 16 | Weak pull-down enable per pin |
| alt_sel | output | 16 | Alternate-function source selected per pin |

## Verification
Each pin in the low bank gets a different configuration nibble: push-pull, open-drain, alternate push-pull, alternate open-drain, pull-up, pull-down, floating and analog. One write therefore tests whether the decoder tells every kind and direction apart. A pin in the high bank checks that the field is placed in the right register. The output data register and the alternate inputs are driven with opposite values, which shows whether the drive source follows the kind bit. Open-drain pins are tried with both source values to separate a driven low from release. The atomic registers are given overlapping set and clear masks, a clear-only word with only upper bits flagged, and patterns that leave neighbouring bits alone. Input patterns with the analog pin held high show masking and one-edge latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int NPINS        = 16;
    localparam int DATA_W       = 32;
    localparam int FIELD_W      = 4;
    localparam int PINS_PER_CFG = DATA_W / FIELD_W;
    localparam int NCFG         = NPINS / PINS_PER_CFG;
    localparam int ADDR_W       = 3;

    localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_IN     = 3'd2;
    localparam logic [ADDR_W-1:0] A_OUT    = 3'd3;
    localparam logic [ADDR_W-1:0] A_SETCLR = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;

    // Reset nibble: kind 01 (floating), direction 00 (input)
    localparam logic [FIELD_W-1:0] FIELD_RST = 4'b0100;
    localparam logic [DATA_W-1:0]  CFG_RST   = {PINS_PER_CFG{FIELD_RST}};

    typedef enum logic [1:0] {
        K_ANALOG = 2'b00,
        K_FLOAT  = 2'b01,
        K_PULLUP = 2'b10,
        K_PULLDN = 2'b11
    } in_kind_e;

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] dir;
    } pin_field_t;

    typedef struct packed {
        logic drive;
        logic open_drain;
        logic alt;
        logic analog;
        logic pu;
        logic pd;
    } pin_ctl_t;

    function automatic pin_ctl_t decode_field(input pin_field_t f);
        pin_ctl_t c;
        c = '0;
        if (f.dir != 2'b00) begin
            c.drive      = 1'b1;
            c.open_drain = f.kind[0];
            c.alt        = f.kind[1];
        end else begin
            unique case (in_kind_e'(f.kind))
                K_ANALOG: c.analog = 1'b1;
                K_PULLUP: c.pu     = 1'b1;
                K_PULLDN: c.pd     = 1'b1;
                default:  ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_port_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NCFG-1:0][DATA_W-1:0]   cfg_words,
    output logic [NPINS-1:0][FIELD_W-1:0] fields,
    output logic [NPINS-1:0]              odr
);

    // Configuration words, one per group of PINS_PER_CFG pins
    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= CFG_RST;
            else if (wr && addr == A_CFG_LO + ADDR_W'(k))
                word_q <= wdata;
        end
        assign cfg_words[k] = word_q;
        for (genvar j = 0; j < PINS_PER_CFG; j++) begin : g_fld
            assign fields[k*PINS_PER_CFG + j] = word_q[j*FIELD_W +: FIELD_W];
        end
    end

    // Output data register with atomic set/clear paths
    logic [NPINS-1:0] set_m, clr_m, odr_d;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        odr_d = odr;
        if (wr) begin
            unique case (addr)
                A_OUT:    odr_d = wdata[NPINS-1:0];
                A_SETCLR: begin
                    set_m = wdata[NPINS-1:0];
                    clr_m = wdata[2*NPINS-1:NPINS];
                end
                A_CLR:    clr_m = wdata[NPINS-1:0];
                default:  ;
            endcase
            if (addr == A_SETCLR || addr == A_CLR)
                odr_d = (odr & ~clr_m) | set_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            odr <= '0;
        else
            odr <= odr_d;
    end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_port_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               odr_bit,
    input  logic               alt_bit,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               pu_en,
    output logic               pd_en,
    output logic               alt_en,
    output logic               analog
);

    pin_ctl_t ctl;
    logic     src;

    always_comb begin
        ctl    = decode_field(pin_field_t'(field));
        src    = ctl.alt ? alt_bit : odr_bit;
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        if (ctl.drive) begin
            if (ctl.open_drain) begin
                pad_out = 1'b0;
                pad_oe  = ~src;
            end else begin
                pad_out = src;
                pad_oe  = 1'b1;
            end
        end
        pu_en  = ctl.pu;
        pd_en  = ctl.pd;
        alt_en = ctl.drive & ctl.alt;
        analog = ctl.analog;
    end

endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] levels,
    input  logic [NPINS-1:0] analog_mask,
    output logic [NPINS-1:0] idr
);

    always_ff @(posedge clk) begin
        if (rst)
            idr <= '0;
        else
            idr <= levels & ~analog_mask;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  alt_out,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pull_up_en,
    output logic [NPINS-1:0]  pull_dn_en,
    output logic [NPINS-1:0]  alt_sel
);

    logic [NCFG-1:0][DATA_W-1:0]   cfg_words;
    logic [NPINS-1:0][FIELD_W-1:0] fields;
    logic [NPINS-1:0]              odr;
    logic [NPINS-1:0]              idr;
    logic [NPINS-1:0]              analog_mask;

    gpio_cfg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cfg_words (cfg_words),
        .fields    (fields),
        .odr       (odr)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_drive u_drv (
            .field   (fields[p]),
            .odr_bit (odr[p]),
            .alt_bit (alt_out[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .pu_en   (pull_up_en[p]),
            .pd_en   (pull_dn_en[p]),
            .alt_en  (alt_sel[p]),
            .analog  (analog_mask[p])
        );
    end

    gpio_in_sample u_in (
        .clk         (clk),
        .rst         (rst),
        .levels      (pad_in),
        .analog_mask (analog_mask),
        .idr         (idr)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG_LO: bus_rdata = cfg_words[0];
            A_CFG_HI: bus_rdata = cfg_words[NCFG-1];
            A_IN:     bus_rdata = {{(DATA_W-NPINS){1'b0}}, idr};
            A_OUT:    bus_rdata = {{(DATA_W-NPINS){1'b0}}, odr};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pull_up_en,
    input logic [NPINS-1:0]  pull_dn_en,
    input logic [NPINS-1:0]  alt_sel
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && alt_sel == '0 &&
                        pull_up_en == '0 && pull_dn_en == '0));

    // R6
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ((pull_up_en | pull_dn_en) & (pad_oe | alt_sel)) == '0);

    // R6
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (pull_up_en & pull_dn_en) == '0);

    // R7
    input_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_IN) |-> ((bus_rdata[NPINS-1:0] & ~$past(pad_in)) == '0));

    // R11
    atomic_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SETCLR || bus_addr == A_CLR) |-> bus_rdata == '0);

    // R9
    setclr_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr) && $past(bus_addr) == A_SETCLR && bus_addr == A_OUT)
        |-> ((bus_rdata[NPINS-1:0] & $past(bus_wdata[NPINS-1:0]))
             == $past(bus_wdata[NPINS-1:0])));

    // R10
    clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr) && $past(bus_addr) == A_CLR && bus_addr == A_OUT)
        |-> ((bus_rdata[NPINS-1:0] & $past(bus_wdata[NPINS-1:0])) == '0));

endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .alt_sel    (alt_sel)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    localparam int CLK_PERIOD = 10;

    // Pin nibbles for pins 7..0: analog, float, pull-down, pull-up,
    // alt open-drain, alt push-pull, open-drain, push-pull
    localparam logic [31:0] CFG_MIX = 32'h04C8D951;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in;
    logic [15:0] alt_out;
    logic [15:0] pad_out, pad_oe, pull_up_en, pull_dn_en, alt_sel;

    int n_checks = 0;
    int n_fail   = 0;

    gpio_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .alt_out    (alt_out),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pull_up_en (pull_up_en),
        .pull_dn_en (pull_dn_en),
        .alt_sel    (alt_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); chk("R1 cfg low", d, 32'h44444444);
        rd(3'd1, d); chk("R1 cfg high", d, 32'h44444444);
        rd(3'd3, d); chk("R1 out data", d, 32'h0);
        chk("R1 oe", {16'h0, pad_oe}, 32'h0);
        chk("R1 pulls", {pull_up_en, pull_dn_en}, 32'h0);
        chk("R1 alt_sel", {16'h0, alt_sel}, 32'h0);
    endtask

    task automatic t_push_pull();
        logic [31:0] d;
        wr(3'd0, CFG_MIX);
        rd(3'd0, d); chk("R2 cfg low readback", d, CFG_MIX);
        wr(3'd3, 32'hFFFF_0001);
        rd(3'd3, d); chk("R12 out readback", d, 32'h0000_0001);
        chk("R3 pp oe", {31'h0, pad_oe[0]}, 32'h1);
        chk("R3 pp high", {31'h0, pad_out[0]}, 32'h1);
        wr(3'd3, 32'h0000_0000);
        chk("R3 pp low", {30'h0, pad_oe[0], pad_out[0]}, 32'h2);
        // pin 9: high bank nibble 1 = push-pull
        wr(3'd1, 32'h4444_4414);
        chk("R2 high bank pin9 only", {16'h0, pad_oe & 16'hFF00}, 32'h0000_0200);
        wr(3'd3, 32'h0000_0200);
        chk("R2 pin9 drives odr", {31'h0, pad_out[9]}, 32'h1);
    endtask

    task automatic t_open_drain();
        wr(3'd3, 32'h0000_0002);
        chk("R4 od release", {30'h0, pad_oe[1], pad_out[1]}, 32'h0);
        wr(3'd3, 32'h0000_0000);
        chk("R4 od drive low", {30'h0, pad_oe[1], pad_out[1]}, 32'h2);
    endtask

    task automatic t_alt();
        wr(3'd3, 32'h0000_0000);
        @(negedge clk); alt_out = 16'h0004; #1;
        chk("R5 alt pp source", {29'h0, alt_sel[2], pad_oe[2], pad_out[2]}, 32'h7);
        wr(3'd3, 32'h0000_0004);
        @(negedge clk); alt_out = 16'h0000; #1;
        chk("R5 alt ignores odr", {30'h0, pad_oe[2], pad_out[2]}, 32'h2);
        chk("R5 alt od drive low", {29'h0, alt_sel[3], pad_oe[3], pad_out[3]}, 32'h6);
        wr(3'd3, 32'h0000_0000);
        @(negedge clk); alt_out = 16'h0008; #1;
        chk("R5 alt od release", {30'h0, pad_oe[3], pad_out[3]}, 32'h0);
        chk("R5 gp pins no alt", {16'h0, alt_sel}, 32'h0000_000C);
    endtask

    task automatic t_pulls();
        chk("R6 pull-up set", {16'h0, pull_up_en}, 32'h0000_0010);
        chk("R6 pull-down set", {16'h0, pull_dn_en}, 32'h0000_0020);
    endtask

    task automatic t_input();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'hFFFF;
        rd(3'd2, d); chk("R7 not yet sampled", d, 32'h0);
        @(negedge clk);
        rd(3'd2, d); chk("R8 analog pin masked", d, 32'h0000_FF7F);
        pad_in = 16'h00A5;
        @(negedge clk);
        rd(3'd2, d); chk("R7 second pattern", d, 32'h0000_0025);
        chk("R8 analog no drive/pull", {29'h0, pad_oe[7], pull_up_en[7], pull_dn_en[7]}, 32'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(3'd3, 32'h0000_00F0);
        wr(3'd4, 32'h0030_0101);
        rd(3'd3, d); chk("R9 set and clear", d, 32'h0000_01C1);
        wr(3'd4, 32'h0004_0004);
        rd(3'd3, d); chk("R9 set wins", d, 32'h0000_01C5);
    endtask

    task automatic t_clr();
        logic [31:0] d;
        wr(3'd5, 32'h0000_0041);
        rd(3'd3, d); chk("R10 clear-only", d, 32'h0000_0184);
        wr(3'd5, 32'hFFFF_0000);
        rd(3'd3, d); chk("R10 upper half ignored", d, 32'h0000_0184);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'h0000;
        @(negedge clk);
        wr(3'd2, 32'h0000_FFFF);
        rd(3'd2, d); chk("R11 input write ignored", d, 32'h0);
        rd(3'd4, d); chk("R11 set/clear reads 0", d, 32'h0);
        rd(3'd5, d); chk("R11 clear-only reads 0", d, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; alt_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_push_pull();
        t_open_drain();
        t_alt();
        t_pulls();
        t_input();
        t_setclr();
        t_clr();
        t_readonly();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule